// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Causes

This block is a bank of general-purpose pins. Software uses a small register port to set up each pin. A pin can be an input or a driven output. An output can take its level from a latch or from a shared blink clock. An input can have its sense inverted. Every pin input passes through a two-stage synchroniser. The synchronised level, XORed with the pin's inversion bit, forms the data-in word. Software reads that word, and both interrupt paths start from it.

There are two interrupt sources per pin. The level source is the data-in bit gated by a level-mask bit. The edge source is a sticky cause bit gated by an edge-mask bit. A 0-to-1 change of the data-in bit sets the cause bit. Software clears it by writing a 0 to its position. The two sources are ORed for each pin. The results are then ORed across each group of eight consecutive pins, which gives one summary interrupt line per group.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register select 0 holds the direction word. A 1 makes the pin an input (`pin_oe` bit low). A 0 makes it an output (`pin_oe` bit high).
- R2: For a pin whose blink bit is 0, `pin_out` follows the output-latch bit (select 1).
- R3: For a pin whose blink bit (select 3) is 1, `pin_out` follows a shared phase. That phase starts low after reset and inverts every `BLINK_HALF` clock cycles. All blinking pins toggle in phase.
- R4: Select 4 reads the data-in word: each pin input after two synchronising flops, XORed with its polarity bit (select 2). Writes to select 4 are ignored.
- R5: The edge-cause word (select 5) sets a bit when that pin's data-in bit goes from 0 to 1. A bit stays set until software clears it. Falling edges are caught by setting the polarity bit.
- R6: A write to select 5 clears each cause bit whose write-data bit is 0. Cause bits whose write-data bit is 1 are left unchanged.
- R7: If a rising edge arrives in the same cycle as a clear of that bit, the bit stays set.
- R8: `irq_grp[g]` is the OR, over pins 8g to 8g+7, of (data-in AND level mask at select 7) OR (edge cause AND edge mask at select 6).
- R9: The direction, output, polarity, blink, edge-mask and level-mask words read back the last value written to them.
- R10: During and after reset, all configuration words and the cause word are 0. This means all pins are enabled outputs driving low and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Level driven to each pad |
| pin_oe | output | 32 | Output enable for each pad, high when the pin is an output |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for both read and write |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq_grp | output | 4 | One summary interrupt per group of eight pins |

## Verification
A behavioural reference model runs alongside the design, and every output is compared with it on every cycle. Input patterns with and without polarity inversion show the difference between the raw pin level and the data-in value that both interrupt paths see. Rising edges, falling edges caught through inversion, partial clears, and a clear that lands on the same cycle as a new edge show sticky edge causes apart from level causes. Masks set on only some groups show which of the four summary lines a pin feeds. Blinking pins mixed with latched outputs show that the blink phase period and the shared phase are separate from the output latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    SEL_DIR    = 3'd0,
    SEL_LATCH  = 3'd1,
    SEL_INV    = 3'd2,
    SEL_BLINK  = 3'd3,
    SEL_DIN    = 3'd4,
    SEL_ECAUSE = 3'd5,
    SEL_EMASK  = 3'd6,
    SEL_LMASK  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end

  // R4
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(meta_q));
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          phase_n;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_n   = wrap ? '0 : cnt_q + 1'b1;
    phase_n = wrap ? ~phase : phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      phase <= phase_n;
    end
  end

  // R3
  blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(phase));
  // R3
  blink_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (phase != $past(phase)));
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int NPINS = 32,
  parameter int GROUP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   din,
  input  logic [NPINS-1:0]   lvl_mask,
  input  logic [NPINS-1:0]   edge_mask,
  input  logic               clr_en,
  input  logic [NPINS-1:0]   clr_keep,
  output logic [NPINS-1:0]   cause,
  output logic [NPINS/GROUP-1:0] irq_grp
);
  localparam int NGRP = NPINS / GROUP;

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] cause_n;
  logic [NPINS-1:0] pin_req;

  always_comb begin
    rise    = din & ~prev_q;
    cause_n = (clr_en ? (cause & clr_keep) : cause) | rise;
    pin_req = (din & lvl_mask) | (cause & edge_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cause  <= '0;
    end else begin
      prev_q <= din;
      cause  <= cause_n;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq_grp[g] = |pin_req[g*GROUP +: GROUP];
  end

  // R7
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((cause & $past(rise)) == $past(rise)));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((cause & $past(~clr_keep & ~rise)) == '0));
  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & ~$past(cause) & ~$past(rise)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_HALF = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_in,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_sel,
  input  logic [NPINS-1:0]       reg_wdata,
  output logic [NPINS-1:0]       reg_rdata,
  output logic [NPINS/GROUP-1:0] irq_grp
);
  localparam int NGRP = NPINS / GROUP;

  logic                   srst_n;
  logic [NPINS-1:0]       pin_sync;
  logic                   blink_phase;
  logic [NPINS-1:0]       din;
  logic [NPINS-1:0]       cause;
  logic [NGRP-1:0]        grp_req;

  logic [NPINS-1:0] dir_q, latch_q, inv_q, blink_q, emask_q, lmask_q;
  logic [NPINS-1:0] dir_n, latch_n, inv_n, blink_n, emask_n, lmask_n;
  logic             clr_en;
  reg_sel_e         sel;

  gpio_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  gpio_sync #(.W(NPINS)) i_sync (
    .clk(clk), .rst_n(srst_n), .async_in(pin_in), .sync_out(pin_sync));

  gpio_blink_timer #(.HALF(BLINK_HALF)) i_blink (
    .clk(clk), .rst_n(srst_n), .phase(blink_phase));

  assign din = pin_sync ^ inv_q;

  gpio_irq_cause #(.NPINS(NPINS), .GROUP(GROUP)) i_cause (
    .clk(clk), .rst_n(srst_n), .din(din), .lvl_mask(lmask_q),
    .edge_mask(emask_q), .clr_en(clr_en), .clr_keep(reg_wdata),
    .cause(cause), .irq_grp(grp_req));

  assign irq_grp = grp_req;

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    clr_en  = reg_wr && (sel == SEL_ECAUSE);
    dir_n   = (reg_wr && sel == SEL_DIR)   ? reg_wdata : dir_q;
    latch_n = (reg_wr && sel == SEL_LATCH) ? reg_wdata : latch_q;
    inv_n   = (reg_wr && sel == SEL_INV)   ? reg_wdata : inv_q;
    blink_n = (reg_wr && sel == SEL_BLINK) ? reg_wdata : blink_q;
    emask_n = (reg_wr && sel == SEL_EMASK) ? reg_wdata : emask_q;
    lmask_n = (reg_wr && sel == SEL_LMASK) ? reg_wdata : lmask_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      inv_q   <= '0;
      blink_q <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      dir_q   <= dir_n;
      latch_q <= latch_n;
      inv_q   <= inv_n;
      blink_q <= blink_n;
      emask_q <= emask_n;
      lmask_q <= lmask_n;
    end
  end

  always_comb begin
    pin_oe = ~dir_q;
    for (int i = 0; i < NPINS; i++) begin
      pin_out[i] = blink_q[i] ? blink_phase : latch_q[i];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:    reg_rdata = dir_q;
      SEL_LATCH:  reg_rdata = latch_q;
      SEL_INV:    reg_rdata = inv_q;
      SEL_BLINK:  reg_rdata = blink_q;
      SEL_DIN:    reg_rdata = din;
      SEL_ECAUSE: reg_rdata = cause;
      SEL_EMASK:  reg_rdata = emask_q;
      default:    reg_rdata = lmask_q;
    endcase
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !reg_wr |=> ($stable(dir_q) && $stable(latch_q) && $stable(inv_q) &&
                 $stable(blink_q) && $stable(emask_q) && $stable(lmask_q)));
  // R1
  oe_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr && sel == SEL_DIR) |=> (pin_oe == ~$past(reg_wdata)));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int HALF = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, reg_rdata;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [NP-1:0] reg_wdata = '0;
  logic [3:0]    irq_grp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  gpio_irq_bank #(.NPINS(NP), .GROUP(8), .BLINK_HALF(HALF)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_grp(irq_grp));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit [NP-1:0] m_dir, m_lat, m_inv, m_blk, m_em, m_lm, m_cause, m_prev, m_s1, m_s2;
  int m_cnt, m_rcnt;
  bit m_phase;

  always @(posedge clk) begin
    bit [NP-1:0] d_old;
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      m_dir = '0; m_lat = '0; m_inv = '0; m_blk = '0; m_em = '0; m_lm = '0;
      m_cause = '0; m_prev = '0; m_s1 = '0; m_s2 = '0; m_cnt = 0; m_phase = 0;
    end else begin
      d_old = m_s2 ^ m_inv;
      for (int b = 0; b < NP; b++) begin
        if (reg_wr && reg_sel == 3'd5 && !reg_wdata[b]) m_cause[b] = 1'b0;
        if (d_old[b] && !m_prev[b]) m_cause[b] = 1'b1;
      end
      m_prev = d_old;
      if (reg_wr) begin
        case (reg_sel)
          3'd0: m_dir = reg_wdata;
          3'd1: m_lat = reg_wdata;
          3'd2: m_inv = reg_wdata;
          3'd3: m_blk = reg_wdata;
          3'd6: m_em  = reg_wdata;
          3'd7: m_lm  = reg_wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_cnt++;
      if (m_cnt == HALF) begin m_cnt = 0; m_phase = !m_phase; end
    end
  end

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    bit [NP-1:0] e_out, e_rd, din;
    bit [3:0] e_irq;
    if (rst_n && !finished) begin
      din = m_s2 ^ m_inv;
      for (int b = 0; b < NP; b++) e_out[b] = m_blk[b] ? m_phase : m_lat[b];
      for (int g = 0; g < 4; g++) begin
        e_irq[g] = 1'b0;
        for (int k = 0; k < 8; k++)
          if ((din[g*8+k] && m_lm[g*8+k]) || (m_cause[g*8+k] && m_em[g*8+k])) e_irq[g] = 1'b1;
      end
      case (reg_sel)
        3'd0: e_rd = m_dir;  3'd1: e_rd = m_lat;  3'd2: e_rd = m_inv;
        3'd3: e_rd = m_blk;  3'd4: e_rd = din;    3'd5: e_rd = m_cause;
        3'd6: e_rd = m_em;   default: e_rd = m_lm;
      endcase
      chk("R1 pin_oe", pin_oe, ~m_dir);
      if (|((pin_out ^ e_out) & m_blk)) chk("R3 blink", pin_out, e_out);
      else chk("R2 pin_out", pin_out, e_out);
      chk("R8 irq_grp", {28'd0, irq_grp}, {28'd0, e_irq});
      if (reg_sel == 3'd4) chk("R4 data-in", reg_rdata, e_rd);
      else if (reg_sel == 3'd5) chk("R5 R6 R7 edge cause", reg_rdata, e_rd);
      else chk("R9 readback", reg_rdata, e_rd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [NP-1:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) begin
      reg_sel = 3'(s);
      step(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    step(3);
    @(negedge clk);
    chk("R10 reset oe", pin_oe, '1);
    chk("R10 reset out", pin_out, '0);
    chk("R10 reset irq", {28'd0, irq_grp}, '0);
    #1 rst_n = 1'b1;
    step(4);
    sweep();
    // R1 R2 R9: direction and latch
    wr(3'd0, 32'h0000_FFFF);
    wr(3'd1, 32'h1234_5678);
    sweep();
    // R4: data-in with and without inversion
    reg_sel = 3'd4;
    pin_in = 32'h0000_00F0; step(4);
    pin_in = 32'h0F0F_A5A5; step(4);
    wr(3'd2, 32'h0000_0F0F);
    reg_sel = 3'd4; step(4);
    wr(3'd4, 32'hFFFF_FFFF);  // ignored
    reg_sel = 3'd4; step(3);
    // R5 R8: edge causes with mask on low two groups only
    wr(3'd6, 32'h0000_FFFF);
    reg_sel = 3'd5;
    pin_in = 32'h0000_0000; step(5);
    pin_in = 32'h0000_0101; step(5);
    pin_in = 32'h0000_0000; step(5);
    wr(3'd2, 32'h0000_0000);  // drop inversion: falling to rising view
    reg_sel = 3'd5; step(4);
    // R6: partial clear
    wr(3'd5, 32'hFFFF_FEFF);
    reg_sel = 3'd5; step(2);
    wr(3'd5, 32'h0000_0000);
    reg_sel = 3'd5; step(2);
    // R5: falling edge via inversion
    pin_in = 32'h0000_0004; step(5);
    wr(3'd2, 32'h0000_0004);
    reg_sel = 3'd5; step(4);
    wr(3'd5, 32'h0000_0000);
    pin_in = 32'h0000_0000; reg_sel = 3'd5; step(5);
    // R7: clear coinciding with a new rising edge
    wr(3'd5, 32'h0000_0000);
    pin_in = 32'h0000_0082; step(2);
    wr(3'd5, 32'h0000_0000);
    reg_sel = 3'd5; step(3);
    // R8: level causes on group 2
    wr(3'd7, 32'h00FF_0000);
    reg_sel = 3'd7;
    pin_in = 32'h0010_0000; step(5);
    pin_in = 32'h0000_0000; step(5);
    wr(3'd6, 32'h0000_0000);
    step(3);
    // R3: blink on some outputs
    wr(3'd3, 32'hF000_0000);
    step(3 * HALF + 2);
    wr(3'd1, 32'hFFFF_0000);
    step(2 * HALF + 1);
    wr(3'd3, 32'h0000_0000);
    sweep();
    step(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule